// File: doc/BRIEF.md
# SMII receive segment serializer

This block sits between the byte-wide receive path of a PHY core and the single serial receive line of a Serial MII link. It emits back-to-back 10-bit segments on one data line, one bit per cycle of the shared reference clock. A SYNC strobe rises on the first bit of every segment. Each segment carries a carrier bit, a data-valid bit and eight payload bits. When no byte is offered, the payload bits carry in-band line status, so the MAC can track link, speed and duplex between frames.

At 100 Mb/s every segment carries new content, and the block takes one byte per segment. At 10 Mb/s each segment goes out ten times in a row, and the block takes a new byte only once every ten segments. The producer sees when a byte is taken through a one-cycle ready strobe, which is raised on the last bit of a segment whose successor carries new content.

Top module: `smii_rx_serializer`

## Requirements
- R1: `sync_o` is high for exactly one cycle at the start of every segment, which is every 10 cycles. The first pulse comes in the first cycle after reset is released.
- R2: `rxd_o` sends one segment bit per clock, in the order: bit 0 carrier, bit 1 data valid, bits 2 to 9 the payload byte with the LSB first.
- R3: At 100 Mb/s (`speed_100`=1), `in_ready` is high on the last bit of every segment, and each segment carries the content taken at that strobe.
- R4: A segment counter counts every segment modulo 10 at either speed. At 10 Mb/s, `in_ready` is high only on the last bit of the segment where that counter wraps, and the same content is repeated for ten segments.
- R5: A byte is taken only in a cycle where `in_ready` and `in_valid` are both high. It appears in the next segment with the data-valid bit set to 1. The inputs in all other cycles have no effect on the output.
- R6: If `in_valid` is low at the strobe, the next segment has the data-valid bit at 0 and a status payload. The payload bits are: bit0 speed (1 = 100 Mb/s), bit1 full duplex, bit2 link up, bit3 jabber, bit4 upper nibble valid, bit5 false carrier, bit6 constant 1, bit7 constant 0.
- R7: The carrier bit of a segment equals `in_crs` as sampled at the strobe that loaded that segment.
- R8: Synchronous active-high `rst` clears both counters and loads an idle status segment. In that segment every bit is 0 except payload bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared reference clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| in_valid | input | 1 | Byte on `in_byte` is frame data |
| in_byte | input | 8 | Receive byte from the PHY core |
| in_crs | input | 1 | Carrier sense |
| st_duplex | input | 1 | Full duplex status |
| st_link | input | 1 | Link up status |
| st_jabber | input | 1 | Jabber status |
| st_nib_ok | input | 1 | Upper nibble valid status |
| st_false_car | input | 1 | False carrier status |
| in_ready | output | 1 | Strobe: inputs are taken this cycle |
| sync_o | output | 1 | Segment start marker |
| rxd_o | output | 1 | Serial receive data |

## Verification
The bench changes every input on every cycle, so a design that latched input away from the strobe would corrupt the serial stream. It runs long stretches at each speed, switches speed in the middle of a run, and applies a reset in the middle of a segment. A wrong repeat count at 10 Mb/s shows up as a ready strobe in the wrong segment or as content that changes early. Swapped status bit positions, a lost constant-one bit, or a data-valid bit set in idle segments would show up as mismatches on `rxd_o`. So would a carrier bit taken from the wrong cycle.

// File: rtl/smii_ser_pkg.sv
package smii_ser_pkg;

    localparam int BYTE_W = 8;
    localparam int SEG_W  = BYTE_W + 2;

    // Packed so that bit 0 is the first bit on the wire.
    typedef struct packed {
        logic [BYTE_W-1:0] payload;
        logic              dv;
        logic              crs;
    } seg_t;

    typedef struct packed {
        logic false_car;
        logic nib_ok;
        logic jabber;
        logic link;
        logic duplex;
        logic speed;
    } line_stat_t;

    function automatic logic [BYTE_W-1:0] pack_status(input line_stat_t s);
        return {1'b0, 1'b1, s.false_car, s.nib_ok, s.jabber, s.link, s.duplex, s.speed};
    endfunction

    function automatic seg_t idle_seg();
        seg_t z;
        z.crs     = 1'b0;
        z.dv      = 1'b0;
        z.payload = 8'h40;
        return z;
    endfunction

endpackage

// File: rtl/smii_seg_timer.sv
module smii_seg_timer #(
    parameter int SEG_LEN = 10,
    parameter int REPEAT  = 10,
    localparam int BW = $clog2(SEG_LEN),
    localparam int RW = $clog2(REPEAT)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [BW-1:0] bit_idx,
    output logic          last_bit,
    output logic          rep_last
);
    logic [RW-1:0] rep_q;

    assign last_bit = (bit_idx == BW'(SEG_LEN - 1));
    assign rep_last = (rep_q == RW'(REPEAT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_idx <= '0;
            rep_q   <= '0;
        end else begin
            bit_idx <= last_bit ? '0 : bit_idx + 1'b1;
            if (last_bit)
                rep_q <= rep_last ? '0 : rep_q + 1'b1;
        end
    end
endmodule

// File: rtl/smii_seg_builder.sv
module smii_seg_builder
    import smii_ser_pkg::*;
(
    input  logic              crs,
    input  logic              valid,
    input  logic [BYTE_W-1:0] data,
    input  line_stat_t        stat,
    output seg_t              seg
);
    always_comb begin
        seg.crs     = crs;
        seg.dv      = valid;
        seg.payload = valid ? data : pack_status(stat);
    end
endmodule

// File: rtl/smii_seg_shifter.sv
module smii_seg_shifter
    import smii_ser_pkg::*;
#(
    localparam int BW = $clog2(SEG_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  seg_t          next_seg,
    input  logic [BW-1:0] bit_idx,
    output logic          rxd
);
    seg_t hold_q;
    logic [SEG_W-1:0] flat;

    assign flat = hold_q;
    assign rxd  = flat[bit_idx];

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= idle_seg();
        else if (load)
            hold_q <= next_seg;
    end
endmodule

// File: rtl/smii_rx_serializer.sv
module smii_rx_serializer
    import smii_ser_pkg::*;
#(
    parameter int REPEAT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              speed_100,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_crs,
    input  logic              st_duplex,
    input  logic              st_link,
    input  logic              st_jabber,
    input  logic              st_nib_ok,
    input  logic              st_false_car,
    output logic              in_ready,
    output logic              sync_o,
    output logic              rxd_o
);
    localparam int BW = $clog2(SEG_W);

    logic [BW-1:0] bit_idx;
    logic          last_bit;
    logic          rep_last;
    line_stat_t    stat;
    seg_t          next_seg;

    smii_seg_timer #(.SEG_LEN(SEG_W), .REPEAT(REPEAT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .bit_idx  (bit_idx),
        .last_bit (last_bit),
        .rep_last (rep_last)
    );

    always_comb begin
        stat.speed     = speed_100;
        stat.duplex    = st_duplex;
        stat.link      = st_link;
        stat.jabber    = st_jabber;
        stat.nib_ok    = st_nib_ok;
        stat.false_car = st_false_car;
    end

    smii_seg_builder u_build (
        .crs   (in_crs),
        .valid (in_valid),
        .data  (in_byte),
        .stat  (stat),
        .seg   (next_seg)
    );

    assign in_ready = last_bit & (speed_100 | rep_last);
    assign sync_o   = (bit_idx == '0);

    smii_seg_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (in_ready),
        .next_seg (next_seg),
        .bit_idx  (bit_idx),
        .rxd      (rxd_o)
    );
endmodule

// File: rtl/smii_ser_chk.sv
module smii_ser_chk #(
    parameter int SEG_LEN = 10,
    parameter int REPEAT  = 10
) (
    input logic clk,
    input logic rst,
    input logic speed_100,
    input logic in_valid,
    input logic in_ready,
    input logic sync_o,
    input logic rxd_o
);
    logic [$clog2(SEG_LEN)-1:0] c_bit;
    logic [$clog2(REPEAT)-1:0]  c_seg;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_bit <= '0;
            c_seg <= '0;
        end else begin
            c_bit <= (c_bit == $bits(c_bit)'(SEG_LEN-1)) ? '0 : c_bit + 1'b1;
            if (c_bit == $bits(c_bit)'(SEG_LEN-1))
                c_seg <= (c_seg == $bits(c_seg)'(REPEAT-1)) ? '0 : c_seg + 1'b1;
        end
    end

    AST_SYNC_SPACING: assert property (@(posedge clk) disable iff (rst) sync_o == (c_bit == '0)); // R1
    AST_READY_LAST_BIT: assert property (@(posedge clk) disable iff (rst) in_ready |-> c_bit == $bits(c_bit)'(SEG_LEN-1)); // R3
    AST_FAST_EVERY_SEG: assert property (@(posedge clk) disable iff (rst) (speed_100 && c_bit == $bits(c_bit)'(SEG_LEN-1)) |-> in_ready); // R3
    AST_SLOW_TENTH_SEG: assert property (@(posedge clk) disable iff (rst) (!speed_100 && in_ready) |-> c_seg == $bits(c_seg)'(REPEAT-1)); // R4
    AST_DV_SET: assert property (@(posedge clk) disable iff (rst) (in_ready && in_valid) |=> ##1 rxd_o); // R5
    AST_DV_CLEAR: assert property (@(posedge clk) disable iff (rst) (in_ready && !in_valid) |=> ##1 !rxd_o); // R6
endmodule

bind smii_rx_serializer smii_ser_chk #(.SEG_LEN(smii_ser_pkg::SEG_W), .REPEAT(REPEAT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .speed_100 (speed_100),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .sync_o    (sync_o),
    .rxd_o     (rxd_o)
);

// File: tb/smii_rx_serializer_tb.sv
module smii_rx_serializer_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic speed_100 = 1'b1;
    logic in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic in_crs = 1'b0;
    logic st_duplex = 1'b0, st_link = 1'b0, st_jabber = 1'b0, st_nib_ok = 1'b0, st_false_car = 1'b0;
    logic in_ready, sync_o, rxd_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    int m_bit;
    int m_seg;
    logic [9:0] m_cur;

    always #5 clk = ~clk;

    smii_rx_serializer dut_i (
        .clk(clk), .rst(rst), .speed_100(speed_100), .in_valid(in_valid),
        .in_byte(in_byte), .in_crs(in_crs), .st_duplex(st_duplex), .st_link(st_link),
        .st_jabber(st_jabber), .st_nib_ok(st_nib_ok), .st_false_car(st_false_car),
        .in_ready(in_ready), .sync_o(sync_o), .rxd_o(rxd_o)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle=%0d actual=%b expected=%b", tag, cyc, act, exp);
        end
    endtask

    // Expected segment (bit0 first) from the requirements R2, R6, R7.
    function automatic logic [9:0] exp_seg();
        logic [7:0] pl;
        if (in_valid) pl = in_byte;
        else pl = {1'b0, 1'b1, st_false_car, st_nib_ok, st_jabber, st_link, st_duplex, speed_100};
        return {pl, in_valid, in_crs};
    endfunction

    task automatic model_reset();
        m_bit = 0;
        m_seg = 0;
        m_cur = 10'h100; // R8: only payload bit 6 set
    endtask

    task automatic drive_rand(input int valid_pct);
        in_valid     = ($urandom_range(99) < valid_pct);
        in_byte      = 8'($urandom);
        in_crs       = 1'($urandom);
        st_duplex    = 1'($urandom);
        st_link      = 1'($urandom);
        st_jabber    = 1'($urandom);
        st_nib_ok    = 1'($urandom);
        st_false_car = 1'($urandom);
    endtask

    // One clock: inputs already driven, compare outputs, then advance the model.
    task automatic step();
        logic adv;
        string tg;
        #1;
        adv = (m_bit == 9) && (speed_100 || m_seg == 9);
        chk("R1 sync", sync_o, m_bit == 0);
        chk(speed_100 ? "R3 ready" : "R4 ready", in_ready, adv);
        if (m_bit == 0) tg = "R7 crs bit";
        else if (m_bit == 1) tg = m_cur[1] ? "R5 dv bit" : "R6 dv bit";
        else tg = m_cur[1] ? "R2 data bit" : "R6 status bit";
        chk(tg, rxd_o, m_cur[m_bit]);
        if (adv) m_cur = exp_seg();
        if (m_bit == 9) m_seg = (m_seg == 9) ? 0 : m_seg + 1;
        m_bit = (m_bit == 9) ? 0 : m_bit + 1;
        @(negedge clk);
        cyc++;
    endtask

    task automatic run(input int n, input int valid_pct);
        for (int i = 0; i < n; i++) begin
            drive_rand(valid_pct);
            step();
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        drive_rand(50);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        #1;
        chk("R8 reset sync", sync_o, 1'b1);
        chk("R8 reset crs", rxd_o, 1'b0);
    endtask

    initial begin
        void'($urandom(32'h5A17));
        @(negedge clk);
        do_reset();
        // R8: idle segment visible for the first segment at 100 Mb/s
        speed_100 = 1'b1;
        run(400, 60);
        // R6: idle-only stretch, all status flags set, then cleared
        for (int i = 0; i < 20; i++) begin
            in_valid = 0; in_crs = 1; st_duplex = 1; st_link = 1; st_jabber = 1;
            st_nib_ok = 1; st_false_car = 1;
            step();
        end
        for (int i = 0; i < 20; i++) begin
            in_valid = 0; in_crs = 0; st_duplex = 0; st_link = 0; st_jabber = 0;
            st_nib_ok = 0; st_false_car = 0;
            step();
        end
        // R4: slow speed, repeated segments
        speed_100 = 1'b0;
        run(1500, 70);
        // R5: all-ones and all-zeros bytes at the boundary
        speed_100 = 1'b1;
        for (int i = 0; i < 20; i++) begin
            drive_rand(100);
            in_byte = (i < 10) ? 8'hFF : 8'h00;
            step();
        end
        // speed switches in mid run
        for (int k = 0; k < 6; k++) begin
            speed_100 = k[0];
            run(237, 50);
        end
        // R8: reset in the middle of a segment
        run(4, 50);
        @(negedge clk);
        do_reset();
        speed_100 = 1'b0;
        run(300, 50);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule